// File: doc/BRIEF.md
# TDM Sync-Framed Serial Shifter

This block moves one parallel word per frame over a time-division-multiplexed serial link. A start strobe latches a transmit word for each lane and a scale value N. From these the block builds a bit clock that runs at the system clock rate divided by 2·N. Each frame opens with a sync pulse that lasts one bit period. While sync is high, every transmit line is held at logic 1.

When sync falls, the block shifts the transmit words out MSB first, one bit per bit period, on all lanes in parallel. Over the same bit periods it collects the same number of bits from the receive line, also MSB first. Sync stays low until the last bit has gone out and come in. The block then returns to idle, pulses a done flag and keeps the received word until the next frame completes.

A polarity input inverts the serial clock output for SPI-style peripherals whose clock idles high.

Top module: `tdm_sync_shifter`

## Requirements
- R1: While a frame is active, sclk_o has a period of 2·N system clock cycles. In each bit period it is high (before polarity) for the first N cycles and low for the last N cycles.
- R2: A scale value of 0 behaves exactly like a scale value of 1.
- R3: A start strobe accepted in idle raises sync_o in the following cycle. sync_o then stays high for exactly 2·N cycles.
- R4: While sync_o is high, every bit of tx_o is 1.
- R5: After sync falls, each lane i drives bits of its word (bits i·WORD_W+WORD_W-1 down to i·WORD_W of tx_word) MSB first. Each bit is held for one bit period, and every lane changes at the start of the bit period.
- R6: rx_i is sampled once per bit period, on the edge where sclk_o falls (before polarity). Samples are assembled MSB first into rx_word.
- R7: A frame lasts (WORD_W+1)·2·N cycles: one sync period followed by WORD_W data periods. sync_o stays low during the data periods. In idle, sync_o and tx_o are 0 and sclk_o equals sclk_inv.
- R8: rx_done is a one-cycle pulse in the cycle after the last bit is sampled. rx_word takes its new value in that same cycle and holds it until the next pulse.
- R9: A start strobe during an active frame has no effect on that frame.
- R10: sclk_inv = 1 inverts sclk_o at all times, so the clock idles high.
- R11: After reset, sync_o, tx_o, rx_done and rx_word are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| scale | input | SCALE_W | Bit clock divider N, latched at start |
| sclk_inv | input | 1 | Invert serial clock polarity |
| start | input | 1 | Begin a frame when idle |
| tx_word | input | LANES·WORD_W | Transmit words, lane 0 in the low bits |
| rx_word | output | WORD_W | Last received word |
| rx_done | output | 1 | One-cycle pulse when rx_word is updated |
| sync_o | output | 1 | Frame sync |
| sclk_o | output | 1 | Serial bit clock |
| tx_o | output | LANES | Serial transmit lines |
| rx_i | input | 1 | Serial receive line |

## Verification
Frames are run with scale 1, 3 and 2, and with scale 0 to show that 0 gives the same timing as 1. Transmit and receive words include all ones, all zeros, alternating bits and asymmetric values with differing lanes. These tell a wrong shift direction apart from a lane swap and from a sampling point that is off by one. A run with the polarity inverted separates clock inversion from timing errors. A start pulsed in the middle of a frame, with different words on the inputs, shows whether a busy frame can be restarted or reloaded.

// File: rtl/tdm_pkg.sv
package tdm_pkg;
   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_SYNC  = 2'd1,
      ST_SHIFT = 2'd2
   } tdm_state_e;
endpackage

// File: rtl/tdm_bitclk_div.sv
module tdm_bitclk_div #(
   parameter int SCALE_W = 8
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               run,
   input  logic [SCALE_W-1:0] half,
   output logic               phase_hi,
   output logic               mid_edge,
   output logic               end_edge
);
   localparam int CNT_W = SCALE_W + 1;

   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] half_w;
   logic [CNT_W-1:0] full_w;

   assign half_w   = {1'b0, half};
   assign full_w   = {half, 1'b0};
   assign phase_hi = cnt < half_w;
   assign mid_edge = cnt == (half_w - CNT_W'(1));
   assign end_edge = cnt == (full_w - CNT_W'(1));

   always_ff @(posedge clk) begin
      if (rst || !run)   cnt <= '0;
      else if (end_edge) cnt <= '0;
      else               cnt <= cnt + CNT_W'(1);
   end

   AST_CNT_IN_PERIOD: assert property (@(posedge clk) disable iff (rst)
      run |-> (cnt < full_w));                                   // R1
endmodule

// File: rtl/tdm_tx_lane.sv
module tdm_tx_lane #(
   parameter int WORD_W = 16
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              load,
   input  logic              shift,
   input  logic [WORD_W-1:0] word,
   output logic              msb
);
   logic [WORD_W-1:0] sreg;

   always_ff @(posedge clk) begin
      if (rst)        sreg <= '0;
      else if (load)  sreg <= word;
      else if (shift) sreg <= {sreg[WORD_W-2:0], 1'b0};
   end

   assign msb = sreg[WORD_W-1];
endmodule

// File: rtl/tdm_rx_capture.sv
module tdm_rx_capture #(
   parameter int WORD_W = 16
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              sample,
   input  logic              last,
   input  logic              rx_i,
   output logic [WORD_W-1:0] rx_word,
   output logic              done
);
   logic [WORD_W-1:0] sreg;

   always_ff @(posedge clk) begin
      if (rst) begin
         sreg    <= '0;
         rx_word <= '0;
         done    <= 1'b0;
      end else begin
         done <= sample && last;
         if (sample) begin
            sreg <= {sreg[WORD_W-2:0], rx_i};
            if (last) rx_word <= {sreg[WORD_W-2:0], rx_i};
         end
      end
   end

   AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
      done |=> !done);                                           // R8
   AST_WORD_HELD: assert property (@(posedge clk) disable iff (rst)
      !$stable(rx_word) |-> done);                               // R8
endmodule

// File: rtl/tdm_sync_shifter.sv
module tdm_sync_shifter
   import tdm_pkg::*;
#(
   parameter int WORD_W  = 16,
   parameter int LANES   = 2,
   parameter int SCALE_W = 8
) (
   input  logic                    clk,
   input  logic                    rst,
   input  logic [SCALE_W-1:0]      scale,
   input  logic                    sclk_inv,
   input  logic                    start,
   input  logic [LANES*WORD_W-1:0] tx_word,
   output logic [WORD_W-1:0]       rx_word,
   output logic                    rx_done,
   output logic                    sync_o,
   output logic                    sclk_o,
   output logic [LANES-1:0]        tx_o,
   input  logic                    rx_i
);
   localparam int IDX_W = $clog2(WORD_W);
   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(WORD_W - 1);

   if (WORD_W < 2)  begin : g_bad_word  $error("WORD_W must be at least 2");  end
   if (LANES < 1)   begin : g_bad_lanes $error("LANES must be at least 1");   end
   if (SCALE_W < 1) begin : g_bad_scale $error("SCALE_W must be at least 1"); end

   tdm_state_e         st;
   logic [SCALE_W-1:0] n_q;
   logic [IDX_W-1:0]   idx;
   logic               phase_hi, mid_edge, end_edge;
   logic               accept, shift_en, sample_en, busy;

   assign busy      = st != ST_IDLE;
   assign accept    = (st == ST_IDLE) && start;
   assign shift_en  = (st == ST_SHIFT) && end_edge;
   assign sample_en = (st == ST_SHIFT) && mid_edge;

   always_ff @(posedge clk) begin
      if (rst) begin
         st  <= ST_IDLE;
         n_q <= SCALE_W'(1);
         idx <= '0;
      end else begin
         unique case (st)
            ST_IDLE: if (start) begin
               st  <= ST_SYNC;
               n_q <= (scale == '0) ? SCALE_W'(1) : scale;
               idx <= '0;
            end
            ST_SYNC: if (end_edge) st <= ST_SHIFT;
            ST_SHIFT: if (end_edge) begin
               if (idx == LAST_IDX) begin
                  st  <= ST_IDLE;
                  idx <= '0;
               end else begin
                  idx <= idx + IDX_W'(1);
               end
            end
            default: st <= ST_IDLE;
         endcase
      end
   end

   tdm_bitclk_div #(.SCALE_W(SCALE_W)) u_div (
      .clk(clk), .rst(rst), .run(busy), .half(n_q),
      .phase_hi(phase_hi), .mid_edge(mid_edge), .end_edge(end_edge)
   );

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      logic msb;
      tdm_tx_lane #(.WORD_W(WORD_W)) u_lane (
         .clk(clk), .rst(rst), .load(accept), .shift(shift_en),
         .word(tx_word[g*WORD_W +: WORD_W]), .msb(msb)
      );
      assign tx_o[g] = (st == ST_SYNC) ? 1'b1 : ((st == ST_SHIFT) ? msb : 1'b0);
   end

   tdm_rx_capture #(.WORD_W(WORD_W)) u_rx (
      .clk(clk), .rst(rst), .sample(sample_en), .last(idx == LAST_IDX),
      .rx_i(rx_i), .rx_word(rx_word), .done(rx_done)
   );

   assign sync_o = st == ST_SYNC;
   assign sclk_o = (busy & phase_hi) ^ sclk_inv;

   AST_SYNC_FORCES_TX: assert property (@(posedge clk) disable iff (rst)
      sync_o |-> (&tx_o));                                       // R4
   AST_IDLE_CLOCK_LEVEL: assert property (@(posedge clk) disable iff (rst)
      !busy |-> (sclk_o == sclk_inv && tx_o == '0));             // R7
   AST_SYNC_THEN_DATA: assert property (@(posedge clk) disable iff (rst)
      $fell(sync_o) |-> (st == ST_SHIFT && idx == '0));          // R7
   AST_BUSY_IGNORES_START: assert property (@(posedge clk) disable iff (rst)
      (st == ST_SHIFT && start && !end_edge) |=> st == ST_SHIFT); // R9
endmodule

// File: tb/tdm_sync_shifter_tb.sv
module tdm_sync_shifter_tb;
   localparam int W = 16;
   localparam int L = 2;
   localparam int S = 8;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic [S-1:0] scale = '0;
   logic sclk_inv = 1'b0;
   logic start = 1'b0;
   logic [L*W-1:0] tx_word = '0;
   logic [W-1:0] rx_word;
   logic rx_done, sync_o, sclk_o;
   logic [L-1:0] tx_o;
   logic rx_i = 1'b0;

   int n_chk = 0;
   int n_bad = 0;
   string tag = "R11";

   always #2 clk = ~clk;

   tdm_sync_shifter #(.WORD_W(W), .LANES(L), .SCALE_W(S)) u_dut (
      .clk(clk), .rst(rst), .scale(scale), .sclk_inv(sclk_inv), .start(start),
      .tx_word(tx_word), .rx_word(rx_word), .rx_done(rx_done), .sync_o(sync_o),
      .sclk_o(sclk_o), .tx_o(tx_o), .rx_i(rx_i)
   );

   // reference model state
   bit act = 0;
   int c = 0;
   int n = 1;
   logic [L*W-1:0] m_tx = '0;
   logic [W-1:0] rx_src = '0;
   logic [W-1:0] m_rx = '0;

   task automatic chk(input bit ok, input string req, input int act_v, input int exp_v);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s (%s) t=%0t actual=%0h expected=%0h", req, tag, $time, act_v, exp_v);
      end
   endtask

   always @(posedge clk) begin
      if (rst) begin
         act = 0; m_rx = '0;
      end else if (!act) begin
         if (start) begin
            act = 1; c = 0;
            n = (scale == 0) ? 1 : int'(scale);
            m_tx = tx_word;
         end
      end else begin
         if (c == 33*n - 1) m_rx = rx_src;
         if (c == (W+1)*2*n - 1) act = 0;
         else c++;
      end
   end

   always @(negedge clk) begin
      if (!rst) begin
         bit e_sync, e_clk, e_done;
         logic [L-1:0] e_tx;
         int b;
         e_sync = act && (c < 2*n);
         e_clk  = (act && ((c % (2*n)) < n)) ^ sclk_inv;
         e_done = act && (c == 33*n);
         b = act ? (c / (2*n)) - 1 : -1;
         for (int i = 0; i < L; i++)
            e_tx[i] = !act ? 1'b0 : (e_sync ? 1'b1 : m_tx[i*W + (W-1-b)]);
         chk(sync_o == e_sync, "R3", sync_o, e_sync);
         chk(sclk_o == e_clk, sclk_inv ? "R10" : "R1", sclk_o, e_clk);
         chk(tx_o == e_tx, e_sync ? "R4" : "R5", tx_o, e_tx);
         chk(rx_done == e_done, "R8", rx_done, e_done);
         chk(rx_word == m_rx, "R6", rx_word, m_rx);
      end
      rx_i = (act && c >= 2*n) ? rx_src[W-1-((c/(2*n))-1)] : 1'b1;
   end

   task automatic frame(input int sc, input bit inv, input logic [W-1:0] w0,
                        input logic [W-1:0] w1, input logic [W-1:0] rw, input bit poke);
      int nn;
      nn = (sc == 0) ? 1 : sc;
      @(negedge clk);
      scale = S'(sc); sclk_inv = inv; tx_word = {w1, w0}; rx_src = rw; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      if (poke) begin
         // R9: restart attempt with other words mid-frame
         repeat (5*nn) @(negedge clk);
         tx_word = ~tx_word; scale = S'(sc + 2); start = 1'b1;
         @(negedge clk);
         start = 1'b0;
         repeat ((W+1)*2*nn - 5*nn) @(negedge clk);
      end else begin
         repeat ((W+1)*2*nn + 2) @(negedge clk);
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      // R11: reset state
      chk(sync_o == 0 && tx_o == 0 && rx_done == 0 && rx_word == 0, "R11",
          {sync_o, tx_o, rx_done}, 0);
      tag = "R1";  frame(1, 0, 16'hFFFF, 16'h0000, 16'hA5C3, 0);
      tag = "R5";  frame(3, 0, 16'hA5C3, 16'h8001, 16'h5555, 0);
      tag = "R2";  frame(0, 0, 16'h1234, 16'hFEDC, 16'h8001, 0);
      tag = "R10"; frame(2, 1, 16'h5555, 16'hAAAA, 16'hFFFF, 0);
      tag = "R9";  frame(2, 0, 16'h0F0F, 16'hC001, 16'h0000, 1);
      tag = "R7";  frame(1, 0, 16'h8000, 16'h0001, 16'h7FFE, 0);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      #100000;
      n_chk++; n_bad++;
      $display("FAIL watchdog expired (R7) actual=1 expected=0");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule